// File: doc/BRIEF.md
# Dithered Phase Generator for Direct Digital Synthesis

This block is the phase path of a direct digital synthesizer. A wide phase accumulator adds a frequency tuning word on every enabled sample and wraps around its range. The block then reduces the accumulator value to a short phase word that addresses a downstream waveform table.

Truncating the phase this way causes periodic spurs in the synthesized waveform. To break up that periodicity, the block can add a pseudo-random word to the accumulator value before the short phase is taken. The random word comes from a maximal-length linear feedback shift register, so the spur energy is spread into a broad noise floor.

Software can reseed the register at any time. A seed of zero is refused, because it would stall the sequence. The waveform table, any amplitude-domain dithering and the converter are outside this block.

Top module: `dds_dither_phase_gen`

## Requirements
- R1: While `rst_n` is low, `acc_out` is 0, `phase_out` is 0 and `phase_valid` is 0. The dither register is initialised to the value 1.
- R2: On a rising edge with `en` high, `acc_out` becomes (`acc_out` + `tune_word`) mod 2^16. With `en` low, `acc_out` keeps its value.
- R3: `phase_valid` equals the value `en` had at the previous rising edge. `phase_out` changes only on edges where `en` is high, on the same edge as `acc_out`.
- R4: On an enabled edge with `dither_on` low, `phase_out` becomes bits [15:11] of the new `acc_out`.
- R5: On an enabled edge with `dither_on` high, `phase_out` becomes bits [15:11] of (new `acc_out` + D) mod 2^16. D is bits [10:0] of the dither register before that edge, so D lies in 0..2047.
- R6: The dither register is 17 bits wide. On each enabled edge without a seed load, it shifts left by one and bit 0 takes state[16] XOR state[13]. This stepping happens whether or not `dither_on` is set.
- R7: A rising edge with `seed_load` high and a nonzero `seed_value` writes `seed_value` into the dither register instead of stepping it. A `seed_load` with `seed_value` 0 leaves the register unchanged and does not step it.
- R8: With a constant odd `tune_word`, `acc_out` first returns to its start value after exactly 65536 enabled samples. With `tune_word` = 4, it returns after 16384.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Sample enable; advances accumulator and dither |
| tune_word | input | 16 | Frequency tuning increment |
| dither_on | input | 1 | Adds the pseudo-random word before truncation |
| seed_load | input | 1 | Load strobe for the dither seed |
| seed_value | input | 17 | New dither register value (zero is refused) |
| phase_out | output | 5 | Registered quantized phase |
| acc_out | output | 16 | Registered accumulator value |
| phase_valid | output | 1 | High the cycle after an enabled sample |

## Verification
The assertions check several rules on every cycle. They check the modular accumulator step and its hold when idle, and the one-cycle delay from `en` to `phase_valid`. They check that plain truncation matches the accumulator's top bits when dither is off. When dither is on, they check that the phase sits at the truncated value or one step above it.

Only the bench's scenarios can show the exact dither sequence, the effect of a reset seed, a refused zero seed and a seed load that collides with a sample. The same holds for the full repetition periods for odd and even increments.

// File: rtl/dds_pkg.sv
// Package: default sizes shared by the dithered phase generator.
// Assumes a 17-bit maximal-length feedback polynomial (taps at bits 16 and 13).
package dds_pkg;
    localparam int DEF_ACC_W   = 16;
    localparam int DEF_PHASE_W = 5;
    localparam int DEF_LFSR_W  = 17;
    localparam logic [DEF_LFSR_W-1:0] DEF_LFSR_TAPS  = 17'h12000;
    localparam logic [DEF_LFSR_W-1:0] DEF_RESET_SEED = 17'h00001;
endpackage

// File: rtl/dds_phase_accum.sv
// Phase accumulator: adds the tuning word on each enabled sample, wrapping
// modulo 2^ACC_W. Also offers the next value combinationally so the
// quantizer can register the phase on the same edge as the accumulator.
module dds_phase_accum #(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [ACC_W-1:0] tune_word,
    output logic [ACC_W-1:0] acc_q,
    output logic [ACC_W-1:0] acc_next
);
    // Next value: modular sum, the carry out is dropped by width.
    always_comb begin
        acc_next = acc_q + tune_word;
    end

    // Accumulator register: advance on enable, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (en) begin
            acc_q <= acc_next;
        end
    end
endmodule

// File: rtl/dds_lfsr_dither.sv
// Dither source: Fibonacci LFSR shifting left, feedback = XOR of tapped bits
// into bit 0. Steps once per enabled sample. A nonzero seed load has priority
// over stepping; a zero seed is refused (state held) so the register never
// locks up. Assumes TAPS describes a maximal-length polynomial.
module dds_lfsr_dither #(
    parameter int                LFSR_W     = 17,
    parameter int                DITHER_W   = 11,
    parameter logic [LFSR_W-1:0] TAPS       = 17'h12000,
    parameter logic [LFSR_W-1:0] RESET_SEED = 17'h00001
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    input  logic                load,
    input  logic [LFSR_W-1:0]   seed,
    output logic [DITHER_W-1:0] dither
);
    logic [LFSR_W-1:0] state_q;
    logic              fb_bit;
    logic              seed_ok;

    // Feedback bit from the tapped state positions.
    always_comb begin
        fb_bit  = ^(state_q & TAPS);
        seed_ok = |seed;
    end

    // State register: seed load wins, otherwise step on enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RESET_SEED;
        end else if (load) begin
            if (seed_ok) begin
                state_q <= seed;
            end
        end else if (step) begin
            state_q <= {state_q[LFSR_W-2:0], fb_bit};
        end
    end

    // Dither word: low state bits before this edge's update.
    assign dither = state_q[DITHER_W-1:0];
endmodule

// File: rtl/dds_phase_quant.sv
// Phase quantizer: forms the top PHASE_W bits of (acc_next + dither) mod
// 2^ACC_W and registers them with a valid flag. Only the carry out of the
// discarded low part is computed (acc_low > ~dither), so no full-width adder
// is spent on bits that are thrown away. Assumes ACC_W > PHASE_W.
module dds_phase_quant #(
    parameter int ACC_W   = 16,
    parameter int PHASE_W = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     dither_on,
    input  logic [ACC_W-1:0]         acc_next,
    input  logic [ACC_W-PHASE_W-1:0] dither,
    output logic [PHASE_W-1:0]       phase_q,
    output logic                     valid_q
);
    localparam int DITHER_W = ACC_W - PHASE_W;

    logic [PHASE_W-1:0] phase_nx;

    generate
        if (DITHER_W > 0) begin : g_dither_path
            logic [DITHER_W-1:0] dither_eff;
            logic [DITHER_W-1:0] dither_inv;
            logic                carry;
            // Carry out of the low part when the gated dither is added.
            always_comb begin
                dither_eff = dither_on ? dither : '0;
                dither_inv = ~dither_eff;
                carry      = acc_next[DITHER_W-1:0] > dither_inv;
                phase_nx   = acc_next[ACC_W-1:DITHER_W] + PHASE_W'(carry);
            end
        end else begin : g_plain_path
            logic unused_ctl;
            // Full-width phase: nothing to truncate or dither.
            always_comb begin
                unused_ctl = dither_on ^ (^dither);
                phase_nx   = acc_next;
            end
        end
    endgenerate

    // Output register: phase updates on enable, valid mirrors enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= en;
            if (en) begin
                phase_q <= phase_nx;
            end
        end
    end
endmodule

// File: rtl/dds_dither_phase_gen.sv
// Top: dithered DDS phase path. Accumulator, LFSR dither source and
// quantizer; phase and accumulator outputs are registered with one cycle
// of latency from the enable. Assumes LFSR_W >= ACC_W - PHASE_W.
module dds_dither_phase_gen
    import dds_pkg::*;
#(
    parameter int                ACC_W      = DEF_ACC_W,
    parameter int                PHASE_W    = DEF_PHASE_W,
    parameter int                LFSR_W     = DEF_LFSR_W,
    parameter logic [LFSR_W-1:0] LFSR_TAPS  = DEF_LFSR_TAPS,
    parameter logic [LFSR_W-1:0] RESET_SEED = DEF_RESET_SEED
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [ACC_W-1:0]   tune_word,
    input  logic               dither_on,
    input  logic               seed_load,
    input  logic [LFSR_W-1:0]  seed_value,
    output logic [PHASE_W-1:0] phase_out,
    output logic [ACC_W-1:0]   acc_out,
    output logic               phase_valid
);
    localparam int DITHER_W = ACC_W - PHASE_W;

    logic [ACC_W-1:0]    acc_next;
    logic [DITHER_W-1:0] dither_word;

    dds_phase_accum #(.ACC_W(ACC_W)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .tune_word (tune_word),
        .acc_q     (acc_out),
        .acc_next  (acc_next)
    );

    dds_lfsr_dither #(
        .LFSR_W     (LFSR_W),
        .DITHER_W   (DITHER_W),
        .TAPS       (LFSR_TAPS),
        .RESET_SEED (RESET_SEED)
    ) u_dither (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (en),
        .load   (seed_load),
        .seed   (seed_value),
        .dither (dither_word)
    );

    dds_phase_quant #(.ACC_W(ACC_W), .PHASE_W(PHASE_W)) u_quant (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .dither_on (dither_on),
        .acc_next  (acc_next),
        .dither    (dither_word),
        .phase_q   (phase_out),
        .valid_q   (phase_valid)
    );
endmodule

// File: rtl/dds_dither_phase_gen_chk.sv
// Checker: cycle rules of the dithered phase generator, observed at its ports.
module dds_dither_phase_gen_chk #(
    parameter int ACC_W   = 16,
    parameter int PHASE_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               en,
    input logic [ACC_W-1:0]   tune_word,
    input logic               dither_on,
    input logic [PHASE_W-1:0] phase_out,
    input logic [ACC_W-1:0]   acc_out,
    input logic               phase_valid
);
    logic [PHASE_W-1:0] acc_top;
    logic [PHASE_W-1:0] acc_top_inc;

    // Truncated accumulator and its successor, for the phase comparisons.
    always_comb begin
        acc_top     = acc_out[ACC_W-1 -: PHASE_W];
        acc_top_inc = acc_top + 1'b1;
    end

    assert_acc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> acc_out == ACC_W'($past(acc_out) + $past(tune_word)));

    assert_acc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(acc_out));

    assert_valid_follows_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> phase_valid);

    assert_valid_low_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !phase_valid);

    assert_phase_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(phase_out));

    assert_plain_trunc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !dither_on) |=> phase_out == acc_top);

    assert_dither_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && dither_on) |=> (phase_out == acc_top) || (phase_out == acc_top_inc));
endmodule

bind dds_dither_phase_gen dds_dither_phase_gen_chk #(
    .ACC_W   (ACC_W),
    .PHASE_W (PHASE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .tune_word   (tune_word),
    .dither_on   (dither_on),
    .phase_out   (phase_out),
    .acc_out     (acc_out),
    .phase_valid (phase_valid)
);

// File: tb/sim_dds_dither_phase_gen.sv
`timescale 1ns/1ps
module sim_dds_dither_phase_gen;
    localparam int N = 16;
    localparam int P = 5;
    localparam int B = N - P;
    localparam int L = 17;
    localparam int WATCHDOG = 190000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic [N-1:0] tw = '0;
    logic         dith = 1'b0;
    logic         sload = 1'b0;
    logic [L-1:0] seed = '0;
    logic [P-1:0] phase_out;
    logic [N-1:0] acc_out;
    logic         phase_valid;

    int checks = 0;
    int failures = 0;
    int cyc_cnt = 0;
    string cur_tag = "R5";

    // Reference state, kept as plain numbers.
    int m_acc = 0;
    int m_phase = 0;
    int m_valid = 0;
    int m_lfsr = 1;

    always #10 clk = ~clk;

    dds_dither_phase_gen u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .tune_word   (tw),
        .dither_on   (dith),
        .seed_load   (sload),
        .seed_value  (seed),
        .phase_out   (phase_out),
        .acc_out     (acc_out),
        .phase_valid (phase_valid)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > WATCHDOG) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc_cnt, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // One clock: drive at negedge, update model after the edge, compare.
    task automatic cyc(input bit e, input int t, input bit d, input bit sl, input int sd);
        int dv;
        int fb;
        en = e; tw = N'(t); dith = d; sload = sl; seed = L'(sd);
        @(posedge clk);
        #5;
        dv = d ? (m_lfsr % (1 << B)) : 0;
        if (e) begin
            m_acc = (m_acc + t) % (1 << N);
            m_phase = ((m_acc + dv) % (1 << N)) / (1 << B);
        end
        m_valid = e ? 1 : 0;
        if (sl) begin
            if (sd != 0) m_lfsr = sd;
        end else if (e) begin
            fb = ((m_lfsr / (1 << 16)) % 2) ^ ((m_lfsr / (1 << 13)) % 2);
            m_lfsr = ((m_lfsr * 2) % (1 << L)) + fb;
        end
        check(int'(acc_out) == m_acc, "R2 accumulator", int'(acc_out), m_acc);
        check(int'(phase_valid) == m_valid, "R3 valid", int'(phase_valid), m_valid);
        if (d) check(int'(phase_out) == m_phase, {cur_tag, " R6 dithered phase"}, int'(phase_out), m_phase);
        else   check(int'(phase_out) == m_phase, "R4 truncated phase", int'(phase_out), m_phase);
        @(negedge clk);
    endtask

    initial begin
        int start;
        int cnt;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(acc_out == '0, "R1 reset acc", int'(acc_out), 0);
        check(phase_out == '0, "R1 reset phase", int'(phase_out), 0);
        check(phase_valid == 1'b0, "R1 reset valid", int'(phase_valid), 0);
        rst_n = 1'b1;

        // Plain truncation, odd increment.
        for (int i = 0; i < 60; i++) cyc(1, 1657, 0, 0, 0);
        // Idle cycles: everything holds, valid drops.
        for (int i = 0; i < 5; i++) cyc(0, 999, 1, 0, 0);
        // Wrap across the boundary with a large increment.
        for (int i = 0; i < 20; i++) cyc(1, 16'hF123, 0, 0, 0);
        // Dithered phase from the reset seed (R1 seed value 1).
        cur_tag = "R1 R5";
        for (int i = 0; i < 300; i++) cyc(1, 13249, 1, 0, 0);
        // Sporadic enable with dither.
        cur_tag = "R5";
        for (int i = 0; i < 100; i++) cyc(i % 3 == 0, 1657, 1, 0, 0);
        // Seed loads: nonzero while enabled, zero refused, load while idle.
        cur_tag = "R7";
        cyc(1, 777, 1, 1, 17'h0ABCD);
        for (int i = 0; i < 40; i++) cyc(1, 777, 1, 0, 0);
        cyc(1, 777, 1, 1, 0);
        for (int i = 0; i < 40; i++) cyc(1, 777, 1, 0, 0);
        cyc(0, 777, 1, 1, 17'h1F00F);
        for (int i = 0; i < 40; i++) cyc(1, 31, 1, 0, 0);
        // Dither enabled then disabled mid-stream.
        cur_tag = "R5";
        for (int i = 0; i < 20; i++) cyc(1, 4097, i % 2 == 0, 0, 0);

        // R8: repetition period for odd and even increments.
        start = int'(acc_out);
        cnt = 0;
        do begin
            cyc(1, 3, 0, 0, 0);
            cnt++;
        end while (int'(acc_out) != start && cnt < 70000);
        check(cnt == 65536, "R8 odd increment period", cnt, 65536);
        start = int'(acc_out);
        cnt = 0;
        do begin
            cyc(1, 4, 0, 0, 0);
            cnt++;
        end while (int'(acc_out) != start && cnt < 70000);
        check(cnt == 16384, "R8 increment 4 period", cnt, 16384);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule